// File: doc/BRIEF.md
# Supply Fault Latch and Power-Good Timer

This block is the timing core of a supervisor for a multi-rail power supply. Comparators outside the block compare each rail against its limits and deliver one digital flag per rail and per fault class: too high, too low and too much current. They also deliver one auxiliary protection flag. An active-low on request and a power-on reset complete the inputs. Each fault class is filtered for its own time before it counts. Under-voltage, over-current and auxiliary checks are held off for a start-up window after the supply is enabled. Over-voltage is watched from the first cycle.

A qualified fault sets a latch. The latch drives the disable output high at once, drops power-good and records which classes caused it. The latch is released only when a debounced off request arrives. On a normal switch-off, power-good drops first and the disable output follows a fixed delay later. Every time is given in microseconds and turned into a whole number of clock cycles from the clock frequency parameter.

Top module: `psu_guard`

## Requirements
- R1: After power-on reset, `fault_out` is 1, `pwr_good` is 0 and `fault_cause` is 0.
- R2: `on_req_n` must hold a new level for SW cycles in a row before it is accepted. An on request held for SW cycles drives `fault_out` low on the SW-th edge. A shorter low pulse leaves `fault_out` high.
- R3: When every under-voltage and over-current flag is clear after enabling, the start-up window runs for the normal length (NRM cycles). `pwr_good` rises NRM edges after `fault_out` falls.
- R4: When an under-voltage or over-current flag is still set after enabling, the window ends after the power-on length (PON cycles). `pwr_good` stays low during this time.
- R5: An over-voltage flag held for OV edges in a row latches a fault on the next edge, with `fault_cause` bit 3 set. This check is active during the start-up window.
- R6: An under-voltage flag held for UV edges in a row after the window latches a fault with `fault_cause` bit 2 set. A shorter pulse has no effect.
- R7: An over-current flag held for OC edges in a row after the window latches a fault with `fault_cause` bit 1 set. A shorter pulse has no effect.
- R8: The auxiliary flag held for XP edges in a row after the window latches a fault with `fault_cause` bit 0 set. This check is blanked like the under-voltage check.
- R9: While the latch is set, `fault_out` stays 1 and `pwr_good` stays 0 for as long as the on request is held, even after the flag clears.
- R10: An accepted off request clears the latch and `fault_cause`, and drops `pwr_good` on the same edge. If the supply was running without a fault, `fault_out` rises OFF edges later.
- R11: After a release, a new accepted on request enables the supply again and `pwr_good` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| on_req_n | input | 1 | Active-low supply on request |
| ov_flag | input | RAILS | Per-rail over-voltage comparator flags |
| uv_flag | input | RAILS | Per-rail under-voltage comparator flags |
| oc_flag | input | RAILS | Per-rail over-current comparator flags |
| xp_flag | input | 1 | Auxiliary protection comparator flag |
| fault_out | output | 1 | 1 = supply disabled (latched fault or off) |
| pwr_good | output | 1 | 1 = rails valid and start-up window over |
| fault_cause | output | 4 | Classes that set the latch: [3] OV, [2] UV, [1] OC, [0] aux |

## Verification
A filter counter that resets too early or saturates at the wrong count moves the edge where `fault_out` rises by one or more cycles. The bench samples one cycle before and at the computed edge, so it sees the shift. A blanking counter that uses the wrong length, or a mode flag stuck in the wrong state, shows up in `pwr_good` tens to hundreds of cycles early or late. A latch or cause register that clears at the wrong time is visible at the ports within one cycle of the accepted off request. A wrong off-delay count appears as a `fault_out` transition at the wrong cycle.

// File: rtl/psu_guard.sv
module psu_guard #(
  parameter int CLK_HZ = 4_000_000,
  parameter int RAILS  = 4,
  parameter int OV_US  = 14,
  parameter int UV_US  = 60,
  parameter int OC_US  = 20_000,
  parameter int XP_US  = 60,
  parameter int SW_US  = 38_000,
  parameter int PON_US = 75_000,
  parameter int NRM_US = 600_000,
  parameter int OFF_US = 4_000
)(
  input  logic             clk,
  input  logic             por_n,
  input  logic             on_req_n,
  input  logic [RAILS-1:0] ov_flag,
  input  logic [RAILS-1:0] uv_flag,
  input  logic [RAILS-1:0] oc_flag,
  input  logic             xp_flag,
  output logic             fault_out,
  output logic             pwr_good,
  output logic [3:0]       fault_cause
);

  function automatic int cyc(input int us);
    longint t;
    t = (longint'(us) * longint'(CLK_HZ) + 64'd500000) / 64'd1000000;
    return (t < 1) ? 1 : int'(t);
  endfunction

  localparam int OV_N  = cyc(OV_US);
  localparam int UV_N  = cyc(UV_US);
  localparam int OC_N  = cyc(OC_US);
  localparam int XP_N  = cyc(XP_US);
  localparam int SW_N  = cyc(SW_US);
  localparam int PON_N = cyc(PON_US);
  localparam int NRM_N = cyc(NRM_US);
  localparam int OFF_N = cyc(OFF_US);
  localparam int NF    = 3 * RAILS + 1;
  localparam int TW    = $clog2(NRM_N + PON_N + SW_N + OC_N + OFF_N + OV_N + UV_N + XP_N + 2);

  logic          on_q, en_q, latched, blank_done, pon, off_busy;
  logic [TW-1:0] sw_cnt, blk_cnt, off_cnt;
  logic [NF-1:0] fl, qual;

  wire sw_diff  = (on_req_n == on_q);
  wire sw_flip  = sw_diff && (sw_cnt == TW'(SW_N - 1));
  wire flags_ok = ~|uv_flag && ~|oc_flag;
  wire [TW-1:0] blim = pon ? TW'(PON_N) : TW'(NRM_N);

  assign fl = {xp_flag, oc_flag, uv_flag, ov_flag};

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_filt
      localparam int LIM = (gi < RAILS) ? OV_N : (gi < 2*RAILS) ? UV_N :
                           (gi < 3*RAILS) ? OC_N : XP_N;
      localparam bit UNBLANKED = (gi < RAILS);
      logic [TW-1:0] cnt;
      wire act = en_q && (UNBLANKED || blank_done);
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 cnt <= '0;
        else if (!act || !fl[gi])   cnt <= '0;
        else if (cnt != TW'(LIM))   cnt <= cnt + 1'b1;
      end
      assign qual[gi] = (cnt == TW'(LIM));
    end
  endgenerate

  wire ov_hit = |qual[RAILS-1:0];
  wire uv_hit = |qual[2*RAILS-1:RAILS];
  wire oc_hit = |qual[3*RAILS-1:2*RAILS];
  wire xp_hit = qual[NF-1];
  wire fault_set = en_q && (ov_hit || uv_hit || oc_hit || xp_hit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        sw_cnt <= '0;
    else if (!sw_diff) sw_cnt <= '0;
    else if (sw_flip)  sw_cnt <= '0;
    else               sw_cnt <= sw_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      on_q        <= 1'b0;
      en_q        <= 1'b0;
      latched     <= 1'b0;
      fault_out   <= 1'b1;
      fault_cause <= '0;
      pon         <= 1'b1;
      blank_done  <= 1'b0;
      blk_cnt     <= '0;
      off_busy    <= 1'b0;
      off_cnt     <= '0;
    end else if (sw_flip) begin
      on_q        <= ~on_q;
      latched     <= 1'b0;
      fault_cause <= '0;
      blk_cnt     <= '0;
      blank_done  <= 1'b0;
      off_cnt     <= '0;
      if (!on_q) begin
        en_q      <= 1'b1;
        fault_out <= 1'b0;
        pon       <= 1'b1;
        off_busy  <= 1'b0;
      end else begin
        en_q      <= 1'b0;
        off_busy  <= ~fault_out;
      end
    end else if (fault_set) begin
      latched     <= 1'b1;
      en_q        <= 1'b0;
      fault_out   <= 1'b1;
      fault_cause <= {ov_hit, uv_hit, oc_hit, xp_hit};
    end else begin
      if (en_q) begin
        if (flags_ok) pon <= 1'b0;
        if (!blank_done) begin
          if (blk_cnt + 1'b1 >= blim) blank_done <= 1'b1;
          else                        blk_cnt    <= blk_cnt + 1'b1;
        end
      end
      if (off_busy) begin
        if (off_cnt == TW'(OFF_N - 1)) begin
          off_busy  <= 1'b0;
          fault_out <= 1'b1;
        end else begin
          off_cnt <= off_cnt + 1'b1;
        end
      end
    end
  end

  assign pwr_good = en_q && blank_done && !pon;

  // R9: power-good never coexists with the disable output
  a_r9_pg_excludes_fault: assert property (@(posedge clk) disable iff (!por_n)
    pwr_good |-> !fault_out);
  // R9: a set latch keeps the supply disabled
  a_r9_latch_holds_off: assert property (@(posedge clk) disable iff (!por_n)
    latched |-> (fault_out && !pwr_good));
  // R5: disabled while requested on means a recorded cause
  a_r5_cause_recorded: assert property (@(posedge clk) disable iff (!por_n)
    (on_q && fault_out) |-> (fault_cause != 4'd0));
  // R10: off release drops power-good on the next cycle
  a_r10_off_drops_pg: assert property (@(posedge clk) disable iff (!por_n)
    $fell(on_q) |-> !pwr_good);
  // R10: a delayed disable happens only with the request off
  a_r10_delay_when_off: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(fault_out) && !latched) |-> !on_q);
  // R3: blanking counter stays within the longer window
  a_r3_blank_bound: assert property (@(posedge clk) disable iff (!por_n)
    blk_cnt <= TW'(NRM_N));

endmodule

// File: tb/psu_guard_bench.sv
module psu_guard_bench;
  localparam int RAILS = 4;
  localparam int OV = 14, UV = 60, OC = 200, XP = 60, SW = 38, PON = 300, NRM = 1200, OFF = 40;

  logic clk = 1'b0, por_n = 1'b0, on_req_n = 1'b1, xp_flag = 1'b0;
  logic [RAILS-1:0] ov_flag = '0, uv_flag = '0, oc_flag = '0;
  logic fault_out, pwr_good;
  logic [3:0] fault_cause;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  psu_guard #(.CLK_HZ(1_000_000), .RAILS(RAILS), .OV_US(OV), .UV_US(UV), .OC_US(OC),
    .XP_US(XP), .SW_US(SW), .PON_US(PON), .NRM_US(NRM), .OFF_US(OFF)) u_psu_guard (
    .clk(clk), .por_n(por_n), .on_req_n(on_req_n), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .oc_flag(oc_flag), .xp_flag(xp_flag), .fault_out(fault_out), .pwr_good(pwr_good),
    .fault_cause(fault_cause));

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int cls);
    case (cls) 0: return OV; 1: return UV; 2: return OC; default: return XP; endcase
  endfunction
  function automatic logic [3:0] code_of(input int cls);
    case (cls) 0: return 4'b1000; 1: return 4'b0100; 2: return 4'b0010; default: return 4'b0001; endcase
  endfunction

  task automatic power_up();
    on_req_n = 1'b0;
    ticks(SW + NRM + 1);
  endtask
  task automatic power_down();
    on_req_n = 1'b1;
    ticks(SW + OFF + 2);
  endtask

  initial begin
    ticks(50_000_000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    ticks(3);
    chk(fault_out == 1 && pwr_good == 0 && fault_cause == 0, "R1 reset", {fault_out, pwr_good}, 2);
    por_n = 1'b1;
    ticks(2);

    on_req_n = 1'b0; ticks(SW - 1); on_req_n = 1'b1; ticks(SW + 5);
    chk(fault_out == 1, "R2 short request ignored", fault_out, 1);

    on_req_n = 1'b0; ticks(SW - 1);
    chk(fault_out == 1, "R2 before debounce", fault_out, 1);
    ticks(1);
    chk(fault_out == 0, "R2 accepted on", fault_out, 0);
    ticks(NRM - 1);
    chk(pwr_good == 0, "R3 pg before window", pwr_good, 0);
    ticks(1);
    chk(pwr_good == 1, "R3 pg after normal window", pwr_good, 1);

    on_req_n = 1'b1; ticks(SW - 1);
    chk(pwr_good == 1, "R10 pg before off debounce", pwr_good, 1);
    ticks(1);
    chk(pwr_good == 0 && fault_out == 0, "R10 pg drops first", {pwr_good, fault_out}, 0);
    ticks(OFF - 1);
    chk(fault_out == 0, "R10 before off delay", fault_out, 0);
    ticks(1);
    chk(fault_out == 1, "R10 after off delay", fault_out, 1);
    ticks(3);

    uv_flag = 4'b0100;
    on_req_n = 1'b0; ticks(SW);
    ticks(PON + UV);
    chk(fault_out == 0 && pwr_good == 0, "R4 short window, no pg", {fault_out, pwr_good}, 0);
    ticks(1);
    chk(fault_out == 1 && fault_cause == 4'b0100, "R4 uv after power-on window", fault_cause, 4);
    uv_flag = '0;
    power_down();

    on_req_n = 1'b0; ticks(SW);
    ov_flag = 4'b0001; ticks(OV);
    chk(fault_out == 0, "R5 ov before filter", fault_out, 0);
    ticks(1);
    chk(fault_out == 1 && fault_cause == 4'b1000, "R5 ov in blanking", fault_cause, 8);
    ov_flag = '0; ticks(50);
    chk(fault_out == 1 && pwr_good == 0 && fault_cause == 4'b1000, "R9 latch holds", fault_cause, 8);
    on_req_n = 1'b1; ticks(SW - 1);
    chk(fault_cause == 4'b1000, "R10 cause before off", fault_cause, 8);
    ticks(1);
    chk(fault_cause == 0 && fault_out == 1, "R10 cause cleared", fault_cause, 0);
    ticks(OFF + 2);

    power_up();
    chk(pwr_good == 1 && fault_out == 0, "R11 re-enable", pwr_good, 1);
    power_down();

    for (int it = 0; it < 28; it++) begin
      int cls, len, rail;
      bit exp_f;
      cls  = (it < 4) ? it : int'($urandom_range(3, 0));
      len  = int'($urandom_range(2 * lim_of(cls), 1));
      if (it >= 4 && it < 8) len = lim_of(it - 4) - 1 + (it % 2);
      rail = int'($urandom_range(RAILS - 1, 0));
      exp_f = (len >= lim_of(cls));
      power_up();
      case (cls)
        0: ov_flag[rail] = 1'b1;
        1: uv_flag[rail] = 1'b1;
        2: oc_flag[rail] = 1'b1;
        default: xp_flag = 1'b1;
      endcase
      ticks(len);
      ov_flag = '0; uv_flag = '0; oc_flag = '0; xp_flag = 1'b0;
      ticks(2);
      if (exp_f)
        chk(fault_out == 1 && pwr_good == 0 && fault_cause == code_of(cls),
            cls == 0 ? "R5 random ov" : cls == 1 ? "R6 random uv" : cls == 2 ? "R7 random oc" : "R8 random aux",
            fault_cause, code_of(cls));
      else
        chk(fault_out == 0 && pwr_good == 1 && fault_cause == 0,
            cls == 0 ? "R5 short ov" : cls == 1 ? "R6 short uv" : cls == 2 ? "R7 short oc" : "R8 short aux",
            fault_cause, 0);
      power_down();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule